// File: doc/BRIEF.md
# Key-locked watchdog timer

A watchdog timer reached over a small 32-bit register bus and clocked by a slow timebase tick (nominally 31250 Hz), which enters as a one-cycle strobe `tick_i` in the system clock domain. Software sets a compare value, a prescale shift and an enable mode. If the prescaled count reaches the compare value before software restarts the count, the block raises a sticky pending flag. When reset generation is enabled, it also emits a one-cycle reset request.

Stray software cannot disturb the watchdog by accident. Every register write must directly follow a write of a magic unlock word to the key register, and each unlock covers only one write. A restart needs a second exact magic word written to the feed register. The counter can run at all times or only while the core reports that it is awake. An optional mode clears the count as soon as the prescaled value equals the compare value.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, config (0x00) reads 0, raw count (0x08) reads 0, compare (0x20) reads 0x0000FFFF, the block is locked, and `irq_o` and `rst_req_o` are 0.
- R2: A write to any offset other than the key register (0x1C) takes effect only if the bus write just before it wrote 0x0051F15E to the key register; otherwise it changes nothing.
- R3: The unlock covers exactly one following write, to any offset, whether or not that write changes anything. A key write of any other value leaves the block locked.
- R4: An accepted write of 0x0D09F00D to the feed register (0x18) sets the raw count to 0. A feed write of any other value leaves the count unchanged.
- R5: The count advances by one on each `tick_i` while config bit 12 is set, or while config bit 13 is set and `core_awake_i` is 1. Otherwise it holds.
- R6: The scaled view (0x10) reads as (raw count >> config[3:0]) truncated to its low 16 bits. An accepted write to the raw count register loads the count.
- R7: Config bit 28 (the pending flag, driven on `irq_o`) sets on the cycle after the scaled count is at or above compare[15:0]. It stays set until an accepted config write puts 0 in bit 28 while the scaled count is below compare.
- R8: `rst_req_o` is high for exactly one cycle, on the cycle the pending flag sets from 0 because of the compare, and only if config bit 8 is 1. It stays 0 in every other case.
- R9: With config bit 9 set, the raw count becomes 0 on the cycle after the scaled count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| core_awake_i | input | 1 | High while the core is awake |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Pending flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions check, on every cycle, the properties that take only a cycle or two to observe:
- the reset request is a single-cycle pulse that coincides with the rise of the pending flag;
- the flag stays set unless software writes to config;
- a refused compare write leaves the compare value unchanged;
- any non-key write leaves the block locked;
- a stopped counter holds its value.

Only the bench scenarios can show the end-to-end results:
- the exact magic values that are accepted or refused;
- the tick on which the compare boundary is crossed;
- the count arithmetic of the awake-gated mode;
- the scaled and truncated view;
- the zero-on-match clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFF_CFG    = 'h00;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_SCALED = 'h10;
  localparam int OFF_FEED   = 'h18;
  localparam int OFF_KEY    = 'h1C;
  localparam int OFF_CMP    = 'h20;

  localparam logic [31:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD   = 32'h0D09_F00D;

  localparam int B_RST_EN  = 8;
  localparam int B_ZERO    = 9;
  localparam int B_ALWAYS  = 12;
  localparam int B_AWAKE   = 13;
  localparam int B_PEND    = 28;
  localparam int SCALE_W   = 4;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          wr_acc_o,
  output logic          unlocked_o
);
  logic unlocked_q;
  logic key_sel;

  assign key_sel = (addr_i == AW'(OFF_KEY));

  // every write consumes the unlock; only a correct key write re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlocked_q <= 1'b0;
    else if (wr_i) unlocked_q <= key_sel && (wdata_i == UNLOCK_WORD);
  end

  assign wr_acc_o   = wr_i && !key_sel && unlocked_q;
  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  input  logic               clear_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CMP_W-1:0]   scaled_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               count_q <= '0;
    else if (load_i)           count_q <= load_val_i;
    else if (clear_i)          count_q <= '0;
    else if (tick_i && run_i)  count_q <= count_q + 1'b1;
  end

  assign count_o  = count_q;
  assign scaled_o = CMP_W'(count_q >> scale_i);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          core_awake_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic               wr_acc, unlocked_q;
  logic               wr_cfg, wr_cnt, wr_feed, wr_cmp;
  logic [SCALE_W-1:0] scale_q;
  logic               rst_en_q, zero_cmp_q, en_always_q, en_awake_q, pend_q;
  logic [CMP_W-1:0]   cmp_q;
  logic [CNT_W-1:0]   count_q;
  logic [CMP_W-1:0]   scaled;
  logic               run, hit, match, feed_ok, rst_q;

  wdog_unlock #(.AW(AW)) u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (req_i && we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_acc_o   (wr_acc),
    .unlocked_o (unlocked_q)
  );

  assign wr_cfg  = wr_acc && (addr_i == AW'(OFF_CFG));
  assign wr_cnt  = wr_acc && (addr_i == AW'(OFF_COUNT));
  assign wr_feed = wr_acc && (addr_i == AW'(OFF_FEED));
  assign wr_cmp  = wr_acc && (addr_i == AW'(OFF_CMP));
  assign feed_ok = wr_feed && (wdata_i == FEED_WORD);

  assign run   = en_always_q || (en_awake_q && core_awake_i);
  assign hit   = (scaled >= cmp_q);
  assign match = (scaled == cmp_q);

  wdog_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .clear_i    (feed_ok || (zero_cmp_q && match)),
    .scale_i    (scale_q),
    .count_o    (count_q),
    .scaled_o   (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q     <= '0;
      rst_en_q    <= 1'b0;
      zero_cmp_q  <= 1'b0;
      en_always_q <= 1'b0;
      en_awake_q  <= 1'b0;
    end else if (wr_cfg) begin
      scale_q     <= wdata_i[SCALE_W-1:0];
      rst_en_q    <= wdata_i[B_RST_EN];
      zero_cmp_q  <= wdata_i[B_ZERO];
      en_always_q <= wdata_i[B_ALWAYS];
      en_awake_q  <= wdata_i[B_AWAKE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '1;
    else if (wr_cmp) cmp_q <= wdata_i[CMP_W-1:0];
  end

  // compare has priority over a software clear of the pending flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= (wr_cfg ? wdata_i[B_PEND] : pend_q) || hit;
      rst_q  <= hit && !pend_q && rst_en_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFF_CFG): begin
        rdata_o[SCALE_W-1:0] = scale_q;
        rdata_o[B_RST_EN]    = rst_en_q;
        rdata_o[B_ZERO]      = zero_cmp_q;
        rdata_o[B_ALWAYS]    = en_always_q;
        rdata_o[B_AWAKE]     = en_awake_q;
        rdata_o[B_PEND]      = pend_q;
      end
      AW'(OFF_COUNT):  rdata_o[CNT_W-1:0] = count_q;
      AW'(OFF_SCALED): rdata_o[CMP_W-1:0] = scaled;
      AW'(OFF_CMP):    rdata_o[CMP_W-1:0] = cmp_q;
      default:         rdata_o = '0;
    endcase
  end

  assign irq_o     = pend_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16,
  parameter int AW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             unlocked_q,
  input logic             wr_acc,
  input logic [CMP_W-1:0] cmp_q,
  input logic [CNT_W-1:0] count_q,
  input logic             en_always_q,
  input logic             en_awake_q,
  input logic             zero_cmp_q
);
  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r8_with_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $rose(irq_o));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_acc && addr_i == AW'(8'h00))) |=> irq_o);

  a_r2_refused_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(8'h20) && !unlocked_q) |=> $stable(cmp_q));

  a_r3_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i != AW'(8'h1C)) |=> !unlocked_q);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_always_q && !en_awake_q && !zero_cmp_q && !wr_acc) |=> $stable(count_q));
endmodule

bind keyed_wdog wdog_checker #(.CNT_W(CNT_W), .CMP_W(CMP_W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o),
  .unlocked_q  (unlocked_q),
  .wr_acc      (wr_acc),
  .cmp_q       (cmp_q),
  .count_q     (count_q),
  .en_always_q (en_always_q),
  .en_awake_q  (en_awake_q),
  .zero_cmp_q  (zero_cmp_q)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
  localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h08, A_SCL = 8'h10,
                         A_FEED = 8'h18, A_KEY = 8'h1C, A_CMP = 8'h20;
  localparam logic [31:0] KEY = 32'h0051_F15E, FOOD = 32'h0D09_F00D;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, awake = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_req;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  keyed_wdog u_keyed_wdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .core_awake_i(awake),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read result in the middle of the read cycle
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  always @(posedge clk) if (rst_n && rst_req) pulses++;

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic kwr(logic [7:0] a, logic [31:0] d);
    bus_wr(A_KEY, KEY);
    bus_wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1 req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst_req", {31'd0, rst_req}, 0);
    rd(A_CFG, 0, "R1 cfg");
    rd(A_CNT, 0, "R1 count");
    rd(A_CMP, 32'h0000_FFFF, "R1 cmp");
    // R2 locked writes refused, keyed write accepted
    bus_wr(A_CMP, 32'd3);
    rd(A_CMP, 32'h0000_FFFF, "R2 unkeyed cmp write");
    kwr(A_CMP, 32'd7);
    rd(A_CMP, 32'd7, "R2 keyed cmp write");
    // R3 one write per unlock, wrong key, consumed by unmapped write
    bus_wr(A_CMP, 32'd9);
    rd(A_CMP, 32'd7, "R3 second write after unlock");
    bus_wr(A_KEY, 32'd1); bus_wr(A_CMP, 32'd9);
    rd(A_CMP, 32'd7, "R3 wrong key");
    bus_wr(A_KEY, KEY); bus_wr(8'h40, 32'd0); bus_wr(A_CMP, 32'd9);
    rd(A_CMP, 32'd7, "R3 unlock used by unmapped write");
    // R5 always mode
    kwr(A_CFG, 32'h0000_1000);
    ticks(3);
    rd(A_CNT, 32'd3, "R5 always mode counts ticks");
    // R4 feed
    kwr(A_FEED, 32'h0000_1234);
    rd(A_CNT, 32'd3, "R4 wrong feed word");
    kwr(A_FEED, FOOD);
    rd(A_CNT, 32'd0, "R4 correct feed");
    ticks(2);
    bus_wr(A_FEED, FOOD);
    rd(A_CNT, 32'd2, "R4 unkeyed feed ignored");
    // R5 awake mode and stopped
    kwr(A_CFG, 32'h0000_2000);
    awake = 1'b0; ticks(2);
    rd(A_CNT, 32'd2, "R5 awake mode, core asleep");
    awake = 1'b1; ticks(2);
    rd(A_CNT, 32'd4, "R5 awake mode, core awake");
    kwr(A_CFG, 32'h0);
    ticks(2);
    rd(A_CNT, 32'd4, "R5 both enables clear");
    // R6 scaled view
    kwr(A_CMP, 32'h0000_FFFF);
    kwr(A_CNT, 32'h50);
    kwr(A_CFG, 32'h4);
    rd(A_SCL, 32'h5, "R6 scale 4");
    rd(A_CNT, 32'h50, "R6 raw count load");
    kwr(A_CNT, 32'h0012_3456);
    kwr(A_CFG, 32'h0);
    rd(A_SCL, 32'h0000_3456, "R6 truncated to 16 bits");
    // R7/R8 compare with reset enabled
    kwr(A_CNT, 32'd0);
    kwr(A_CMP, 32'd5);
    kwr(A_CFG, 32'h0000_1100);
    chk("R7 no pending before compare", {31'd0, irq}, 0);
    ticks(4);
    idle(2);
    chk("R7 below compare", {31'd0, irq}, 0);
    chk("R8 no pulse below compare", pulses, 0);
    ticks(1);
    idle(3);
    chk("R7 pending at compare", {31'd0, irq}, 1);
    chk("R8 single pulse", pulses, 1);
    // R7 sticky while at/above compare, clears once below
    kwr(A_CFG, 32'h0);
    rd(A_CFG, 32'h1000_0000, "R7 clear refused while at compare");
    kwr(A_FEED, FOOD);
    kwr(A_CFG, 32'h0);
    rd(A_CFG, 32'h0, "R7 clear after feed");
    chk("R7 irq low", {31'd0, irq}, 0);
    // R9 zero on match, reset disabled -> no pulse
    kwr(A_CMP, 32'd3);
    kwr(A_CFG, 32'h0000_1200);
    ticks(3);
    rd(A_CNT, 32'd0, "R9 count cleared on match");
    rd(A_CFG, 32'h1000_1200, "R9 pending set on match");
    chk("R8 no pulse with reset disabled", pulses, 1);
    idle(4);
    done = 1'b1;
    summary();
  end
endmodule